// File: doc/BRIEF.md
# Receive Frame DMA Request Engine

This block hands one fully received and accepted frame from on-chip frame storage to host memory through a DMA handshake in the style of a PC expansion bus. When storage offers a complete frame, the engine takes it and raises the request line of the selected request/acknowledge pair. Each low pulse on the matching acknowledge input carries one 16-bit word. The first word is the frame status, the second is the frame length in bytes, and the frame data words follow in storage order.

The request runs either continuously or under burst pacing. Burst pacing holds the request high for about 28 µs, then low for about 1.3 µs, and repeats. The request falls before the final word, because the host latches the request and performs one more cycle. The engine serves that cycle with the last word.

On completion the engine records where the frame landed, as an offset inside a host ring of 16 or 64 Kbytes. It adds the frame to a frame counter and a byte counter, both cleared when read. It also sets an event flag, raises an interrupt if that is enabled, and pulses a buffer-release strobe so that the local storage can be freed.

Top module: `rx_dma_engine`

## Requirements
- R1: While no frame is offered, every request output stays low. An offered frame (`frame_valid` high while idle) is taken in that cycle (`frame_take` high), and the request of the selected pair rises one cycle later.
- R2: Successive acknowledge pulses deliver the status word, then the length word, then data words 0, 1, 2, … read from storage. `dma_data` holds the current word while the acknowledge is low, and the engine advances to the next word when the acknowledge returns high.
- R3: A frame of L bytes takes 2 + ceil(L/2) words. The request falls as soon as only one word remains. The next acknowledge pulse still delivers that last word and completes the transfer.
- R4: With burst pacing off, the request stays high from the first word until one word remains. With burst pacing on, the request is high for CLK_MHZ·BURST_ON_NS/1000 cycles, then low for CLK_MHZ·BURST_OFF_NS/1000 cycles, and this repeats from the start of the transfer.
- R5: `cfg_chan` values 0, 1 and 2 pick bit 0, 1 or 2 of `dma_req` and `dma_ack_n`. The value is latched when a frame is taken. At most one request bit is ever high, and acknowledges on the other pairs have no effect.
- R6: On completion `sof_offset` takes the running ring pointer, which starts at 0. The pointer then advances by 4 + 2·ceil(L/2) bytes, modulo 16384 when `cfg_big_ring` is 0 and modulo 65536 when it is 1.
- R7: `frame_count` bits 11:0 count completed frames since the last read, and bits 15:12 read as 0. A `fcnt_rd` pulse clears the count. If a completion falls in the same cycle as the read, the count afterwards is 1.
- R8: `byte_count` adds 4 + 2·ceil(L/2) per completed frame and clears on a `bcnt_rd` pulse. If a completion falls in the same cycle as the read, the count afterwards equals that frame's bytes.
- R9: The cycle after completion, `evt_rxdma` is set and `buf_release` is high for exactly one cycle. `irq` equals `evt_rxdma` AND `cfg_irq_en`. `evt_clr` clears the event, but a completion in the same cycle takes priority.
- R10: Acknowledge pulses while idle change no output, counter or event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | A complete accepted frame is waiting in storage |
| frame_status | input | 16 | Receive status word of the waiting frame |
| frame_len | input | 16 | Length of the waiting frame in bytes |
| frame_take | output | 1 | Frame taken this cycle |
| mem_addr | output | ADDR_W | Data word index into frame storage |
| mem_data | input | 16 | Storage word at `mem_addr` (combinational read) |
| cfg_chan | input | 2 | Request/acknowledge pair select (0..2) |
| cfg_burst | input | 1 | Burst pacing enable |
| cfg_big_ring | input | 1 | Host ring size: 0 = 16 KB, 1 = 64 KB |
| cfg_irq_en | input | 1 | Interrupt enable for the completion event |
| dma_req | output | 3 | Request lines, one per pair |
| dma_ack_n | input | 3 | Active-low acknowledge lines, one per pair |
| dma_data | output | 16 | Word delivered during the acknowledge |
| sof_offset | output | 16 | Ring offset of the last transferred frame |
| frame_count | output | 16 | Frames transferred since the last read |
| byte_count | output | BCNT_W | Bytes transferred since the last read |
| fcnt_rd | input | 1 | Read strobe, clears the frame count |
| bcnt_rd | input | 1 | Read strobe, clears the byte count |
| evt_clr | input | 1 | Clears the completion event |
| evt_rxdma | output | 1 | Completion event flag |
| irq | output | 1 | Interrupt request |
| buf_release | output | 1 | One-cycle strobe that frees the frame's storage |

## Verification
Some properties are checked on every cycle. At most one request bit is high. No request is high while idle or in a burst off phase. The word index steps by one on each acknowledge rise. A read strobe leaves its counter at zero unless a completion falls in the same cycle. Each completion is followed by the event and the release strobe, and a small ring keeps the offset below 16 KB. Other behaviour only the bench scenarios can show. These include the exact word order against stored data, the request falling one word early, the exact burst on and off lengths, and offset wrap across many frames and a ring-size change. They also include reads that coincide with a completion and acknowledges that are ignored while idle or on other pairs.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_PAIRS = 3;
    localparam int WCNT_W    = 17;

    typedef enum logic [0:0] {
        XS_IDLE = 1'b0,
        XS_MOVE = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] length;
    } frame_hdr_t;

    typedef struct packed {
        logic              fire;
        logic [WCNT_W-1:0] words;
    } xfer_done_t;

    // status word + length word + ceil(len/2) data words
    function automatic logic [WCNT_W-1:0] frame_words(input logic [WORD_W-1:0] len);
        logic [WCNT_W-1:0] half;
        half = ({1'b0, len} + WCNT_W'(1)) >> 1;
        return half + WCNT_W'(2);
    endfunction

    function automatic logic [WORD_W-1:0] ring_mask(input logic big);
        return big ? 16'hFFFF : 16'h3FFF;
    endfunction

endpackage

// File: rtl/rxdma_pacer.sv
module rxdma_pacer #(
    parameter int ON_CYC  = 2800,
    parameter int OFF_CYC = 130
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic pace_off
);
    localparam int CW = $clog2(ON_CYC + OFF_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          off_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            off_q <= 1'b0;
        end else if (!off_q) begin
            if (cnt_q == CW'(ON_CYC - 1)) begin
                cnt_q <= '0;
                off_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end else begin
            if (cnt_q == CW'(OFF_CYC - 1)) begin
                cnt_q <= '0;
                off_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign pace_off = off_q;

    // R4: the phase counter never runs past the length of its phase
    a_r4_phase_bound: assert property (@(posedge clk) disable iff (rst)
        off_q |-> (cnt_q < CW'(OFF_CYC)));
    a_r4_on_bound: assert property (@(posedge clk) disable iff (rst)
        !off_q |-> (cnt_q < CW'(ON_CYC)));

endmodule

// File: rtl/rxdma_xfer.sv
module rxdma_xfer
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_valid,
    input  frame_hdr_t           hdr_in,
    input  logic [1:0]           cfg_chan,
    input  logic                 cfg_burst,
    input  logic [NUM_PAIRS-1:0] ack_n,
    input  logic                 pace_off,
    input  logic [WORD_W-1:0]    mem_data,
    output logic                 frame_take,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [NUM_PAIRS-1:0] dma_req,
    output logic [WORD_W-1:0]    dma_data,
    output logic                 burst_run,
    output logic                 idle,
    output xfer_done_t           done
);
    xfer_state_e       state_q;
    frame_hdr_t        hdr_q;
    logic [1:0]        chan_q;
    logic              burst_q;
    logic [WCNT_W-1:0] left_q;
    logic [WCNT_W-1:0] total_q;
    logic [WCNT_W-1:0] idx_q;
    logic              ack_prev_q;
    logic              ack_sel;
    logic              ack_rise;
    logic              req_int;
    logic [WCNT_W-1:0] data_idx;

    always_comb begin
        ack_sel = 1'b1;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (chan_q == 2'(p)) ack_sel = ack_n[p];
        end
    end

    assign ack_rise   = ack_sel && !ack_prev_q;
    assign frame_take = (state_q == XS_IDLE) && frame_valid;
    assign idle       = (state_q == XS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= XS_IDLE;
            hdr_q      <= '0;
            chan_q     <= '0;
            burst_q    <= 1'b0;
            left_q     <= '0;
            total_q    <= '0;
            idx_q      <= '0;
            ack_prev_q <= 1'b1;
        end else begin
            ack_prev_q <= ack_sel;
            unique case (state_q)
                XS_IDLE: begin
                    if (frame_valid) begin
                        state_q    <= XS_MOVE;
                        hdr_q      <= hdr_in;
                        chan_q     <= cfg_chan;
                        burst_q    <= cfg_burst;
                        left_q     <= frame_words(hdr_in.length);
                        total_q    <= frame_words(hdr_in.length);
                        idx_q      <= '0;
                        ack_prev_q <= 1'b1;
                    end
                end
                XS_MOVE: begin
                    if (ack_rise) begin
                        left_q <= left_q - WCNT_W'(1);
                        idx_q  <= idx_q + WCNT_W'(1);
                        if (left_q == WCNT_W'(1)) state_q <= XS_IDLE;
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    // request drops while only the final word is outstanding
    assign req_int = (state_q == XS_MOVE) && (left_q > WCNT_W'(1)) && !pace_off;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        assign dma_req[g] = req_int && (chan_q == 2'(g));
    end

    assign data_idx  = idx_q - WCNT_W'(2);
    assign mem_addr  = (idx_q < WCNT_W'(2)) ? '0 : data_idx[ADDR_W-1:0];
    assign burst_run = (state_q == XS_MOVE) && burst_q;

    always_comb begin
        if (idx_q == WCNT_W'(0))      dma_data = hdr_q.status;
        else if (idx_q == WCNT_W'(1)) dma_data = hdr_q.length;
        else                          dma_data = mem_data;
    end

    assign done.fire  = (state_q == XS_MOVE) && ack_rise && (left_q == WCNT_W'(1));
    assign done.words = total_q;

    // R2: each acknowledge rise in mid-frame moves exactly one word on
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        ((state_q == XS_MOVE) && ack_rise && (left_q > WCNT_W'(1)))
        |=> ((idx_q == $past(idx_q) + WCNT_W'(1)) && (state_q == XS_MOVE)));
    // R1: no request without a frame in flight
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == XS_IDLE) |-> (dma_req == '0));
    // R3: the final word is delivered with the request already low
    a_r3_last_unrequested: assert property (@(posedge clk) disable iff (rst)
        done.fire |-> (dma_req == '0));

endmodule

// File: rtl/rxdma_stats.sv
module rxdma_stats
    import rxdma_pkg::*;
#(
    parameter int BCNT_W = 16,
    parameter int FCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_done_t        done,
    input  logic              cfg_big_ring,
    input  logic              cfg_irq_en,
    input  logic              fcnt_rd,
    input  logic              bcnt_rd,
    input  logic              evt_clr,
    output logic [WORD_W-1:0] sof_offset,
    output logic [WORD_W-1:0] frame_count,
    output logic [BCNT_W-1:0] byte_count,
    output logic              evt_rxdma,
    output logic              irq,
    output logic              buf_release
);
    localparam int PAD_W = WORD_W - FCNT_W;

    logic [WORD_W-1:0] ptr_q;
    logic [WORD_W-1:0] sof_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic              evt_q;
    logic              rel_q;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] frame_bytes;
    logic [BCNT_W-1:0] frame_bytes_b;

    assign mask          = ring_mask(cfg_big_ring);
    assign frame_bytes   = WORD_W'({done.words, 1'b0});
    assign frame_bytes_b = BCNT_W'({done.words, 1'b0});

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            sof_q  <= '0;
            fcnt_q <= '0;
            bcnt_q <= '0;
            evt_q  <= 1'b0;
            rel_q  <= 1'b0;
        end else begin
            rel_q <= done.fire;
            if (done.fire) begin
                sof_q <= ptr_q & mask;
                ptr_q <= (ptr_q + frame_bytes) & mask;
            end
            // a read in the same cycle as a completion keeps that completion
            if (fcnt_rd)        fcnt_q <= done.fire ? FCNT_W'(1) : '0;
            else if (done.fire) fcnt_q <= fcnt_q + FCNT_W'(1);
            if (bcnt_rd)        bcnt_q <= done.fire ? frame_bytes_b : '0;
            else if (done.fire) bcnt_q <= bcnt_q + frame_bytes_b;
            if (done.fire)      evt_q <= 1'b1;
            else if (evt_clr)   evt_q <= 1'b0;
        end
    end

    assign sof_offset  = sof_q;
    assign frame_count = {{PAD_W{1'b0}}, fcnt_q};
    assign byte_count  = bcnt_q;
    assign evt_rxdma   = evt_q;
    assign irq         = evt_q && cfg_irq_en;
    assign buf_release = rel_q;

    // R7: a read with no coinciding completion empties the frame counter
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (fcnt_rd && !done.fire) |=> (fcnt_q == '0));
    // R8: same for the byte counter
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (bcnt_rd && !done.fire) |=> (bcnt_q == '0));
    // R9: a completion always leaves the event set and a release strobe
    a_r9_event_release: assert property (@(posedge clk) disable iff (rst)
        done.fire |=> (evt_q && rel_q));
    // R6: a small ring never yields an offset at or above 16 KB
    a_r6_small_ring: assert property (@(posedge clk) disable iff (rst)
        (done.fire && !cfg_big_ring) |=> (sof_q[15:14] == 2'b00));

endmodule

// File: rtl/rx_dma_engine.sv
module rx_dma_engine
    import rxdma_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int BURST_ON_NS  = 28000,
    parameter int BURST_OFF_NS = 1300,
    parameter int ADDR_W       = 10,
    parameter int BCNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic [15:0]       frame_status,
    input  logic [15:0]       frame_len,
    output logic              frame_take,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_data,
    input  logic [1:0]        cfg_chan,
    input  logic              cfg_burst,
    input  logic              cfg_big_ring,
    input  logic              cfg_irq_en,
    output logic [2:0]        dma_req,
    input  logic [2:0]        dma_ack_n,
    output logic [15:0]       dma_data,
    output logic [15:0]       sof_offset,
    output logic [15:0]       frame_count,
    output logic [BCNT_W-1:0] byte_count,
    input  logic              fcnt_rd,
    input  logic              bcnt_rd,
    input  logic              evt_clr,
    output logic              evt_rxdma,
    output logic              irq,
    output logic              buf_release
);
    localparam int ON_CYC  = CLK_MHZ * BURST_ON_NS / 1000;
    localparam int OFF_CYC = CLK_MHZ * BURST_OFF_NS / 1000;

    frame_hdr_t hdr_in;
    xfer_done_t done;
    logic       burst_run;
    logic       pace_off;
    logic       idle;

    assign hdr_in.status = frame_status;
    assign hdr_in.length = frame_len;

    rxdma_pacer #(
        .ON_CYC (ON_CYC),
        .OFF_CYC(OFF_CYC)
    ) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .run     (burst_run),
        .pace_off(pace_off)
    );

    rxdma_xfer #(
        .ADDR_W(ADDR_W)
    ) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .frame_valid(frame_valid),
        .hdr_in     (hdr_in),
        .cfg_chan   (cfg_chan),
        .cfg_burst  (cfg_burst),
        .ack_n      (dma_ack_n),
        .pace_off   (pace_off),
        .mem_data   (mem_data),
        .frame_take (frame_take),
        .mem_addr   (mem_addr),
        .dma_req    (dma_req),
        .dma_data   (dma_data),
        .burst_run  (burst_run),
        .idle       (idle),
        .done       (done)
    );

    rxdma_stats #(
        .BCNT_W(BCNT_W),
        .FCNT_W(12)
    ) u_stats (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .cfg_big_ring(cfg_big_ring),
        .cfg_irq_en  (cfg_irq_en),
        .fcnt_rd     (fcnt_rd),
        .bcnt_rd     (bcnt_rd),
        .evt_clr     (evt_clr),
        .sof_offset  (sof_offset),
        .frame_count (frame_count),
        .byte_count  (byte_count),
        .evt_rxdma   (evt_rxdma),
        .irq         (irq),
        .buf_release (buf_release)
    );

    // R5: one pair at most carries a request
    a_r5_single_pair: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dma_req));
    // R4: a burst off phase silences every request line
    a_r4_off_silent: assert property (@(posedge clk) disable iff (rst)
        pace_off |-> (dma_req == '0));
    // R10: completion cannot come out of an idle engine
    a_r10_idle_no_done: assert property (@(posedge clk) disable iff (rst)
        idle |-> !done.fire);

endmodule

// File: tb/rx_dma_engine_bench.sv
module rx_dma_engine_bench;

    localparam int ON_CYC  = 20;
    localparam int OFF_CYC = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_valid = 1'b0;
    logic [15:0] frame_status = '0;
    logic [15:0] frame_len = '0;
    logic        frame_take;
    logic [9:0]  mem_addr;
    logic [15:0] mem_data;
    logic [1:0]  cfg_chan = '0;
    logic        cfg_burst = 1'b0;
    logic        cfg_big_ring = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic [2:0]  dma_req;
    logic [2:0]  dma_ack_n = 3'b111;
    logic [15:0] dma_data;
    logic [15:0] sof_offset;
    logic [15:0] frame_count;
    logic [15:0] byte_count;
    logic        fcnt_rd = 1'b0;
    logic        bcnt_rd = 1'b0;
    logic        evt_clr = 1'b0;
    logic        evt_rxdma;
    logic        irq;
    logic        buf_release;

    logic [15:0] mem [0:1023];
    assign mem_data = mem[mem_addr];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural model state
    int exp_ptr  = 0;
    int exp_sof  = 0;
    int exp_fcnt = 0;
    int exp_bcnt = 0;
    bit exp_evt  = 0;

    always #5 clk = ~clk;

    rx_dma_engine #(
        .CLK_MHZ     (100),
        .BURST_ON_NS (200),
        .BURST_OFF_NS(50),
        .ADDR_W      (10),
        .BCNT_W      (16)
    ) u_rx_dma_engine (
        .clk(clk), .rst(rst),
        .frame_valid(frame_valid), .frame_status(frame_status), .frame_len(frame_len),
        .frame_take(frame_take), .mem_addr(mem_addr), .mem_data(mem_data),
        .cfg_chan(cfg_chan), .cfg_burst(cfg_burst), .cfg_big_ring(cfg_big_ring),
        .cfg_irq_en(cfg_irq_en), .dma_req(dma_req), .dma_ack_n(dma_ack_n),
        .dma_data(dma_data), .sof_offset(sof_offset), .frame_count(frame_count),
        .byte_count(byte_count), .fcnt_rd(fcnt_rd), .bcnt_rd(bcnt_rd),
        .evt_clr(evt_clr), .evt_rxdma(evt_rxdma), .irq(irq), .buf_release(buf_release)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            fails <= fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, expv, cycles);
        end
    endtask

    task automatic check_state(input string req);
        chk(sof_offset == 16'(exp_sof), {req, " sof"}, sof_offset, exp_sof);
        chk(frame_count == 16'(exp_fcnt), {req, " fcnt"}, frame_count, exp_fcnt);
        chk(byte_count == 16'(exp_bcnt), {req, " bcnt"}, byte_count, exp_bcnt);
        chk(evt_rxdma == exp_evt, {req, " evt"}, evt_rxdma, exp_evt);
        chk(irq == (exp_evt && cfg_irq_en), "R9 irq", irq, exp_evt && cfg_irq_en);
    endtask

    // one frame: offer, optional burst probe, optional foreign acks, move all words
    task automatic move_frame(input logic [15:0] st, input int len, input int ch,
                              input bit burst, input bit probe, input bit noise,
                              input bit coincide);
        int nw;
        int bytes;
        logic [15:0] exp_w [$];
        nw = 2 + (len + 1) / 2;
        bytes = 2 * nw;
        for (int i = 0; i < (len + 1) / 2; i++) mem[i] = 16'(16'h5A00 ^ (i * 37) ^ len);
        exp_w.push_back(st);
        exp_w.push_back(16'(len));
        for (int i = 0; i < (len + 1) / 2; i++) exp_w.push_back(mem[i]);

        @(negedge clk);
        cfg_chan = 2'(ch); cfg_burst = burst;
        frame_status = st; frame_len = 16'(len); frame_valid = 1'b1;
        #1;
        chk(frame_take == 1'b1, "R1 take", frame_take, 1);
        chk(dma_req == 3'b000, "R1 no early req", dma_req, 0);
        @(negedge clk);
        frame_valid = 1'b0;
        chk(dma_req == 3'(1 << ch), "R1/R5 req on pair", dma_req, 1 << ch);

        if (probe) begin
            int hi = 0;
            int lo = 0;
            for (int i = 0; i < ON_CYC; i++) begin
                if (dma_req[ch]) hi++;
                @(negedge clk);
            end
            for (int i = 0; i < OFF_CYC; i++) begin
                if (!dma_req[ch] && dma_req == 3'b000) lo++;
                @(negedge clk);
            end
            chk(hi == ON_CYC, "R4 burst on length", hi, ON_CYC);
            chk(lo == OFF_CYC, "R4 burst off length", lo, OFF_CYC);
            chk(dma_req[ch] == 1'b1, "R4 burst resumes", dma_req[ch], 1);
        end

        if (noise) begin
            dma_ack_n = ~(3'b111 & ~3'(1 << ch)) | 3'(1 << ch);
            dma_ack_n = 3'b111 & ~(3'b111 & ~3'(1 << ch));
            @(negedge clk);
            dma_ack_n = 3'b111;
            @(negedge clk);
        end

        for (int k = 0; k < nw; k++) begin
            if (k < nw - 1) begin
                while (!dma_req[ch]) begin
                    if (!burst) chk(1'b0, "R4 continuous req dropped", dma_req, 1 << ch);
                    @(negedge clk);
                end
                if (k == 0 || k == nw - 2) chk(dma_req == 3'(1 << ch), "R5 only selected pair", dma_req, 1 << ch);
            end else begin
                chk(dma_req == 3'b000, "R3 req low before last word", dma_req, 0);
            end
            dma_ack_n[ch] = 1'b0;
            @(negedge clk);
            chk(dma_data == exp_w[k], "R2 word order", dma_data, exp_w[k]);
            dma_ack_n[ch] = 1'b1;
            if (k == nw - 1 && coincide) begin
                fcnt_rd = 1'b1; bcnt_rd = 1'b1;
                chk(frame_count == 16'(exp_fcnt), "R7 read value", frame_count, exp_fcnt);
            end
            @(negedge clk);
            fcnt_rd = 1'b0; bcnt_rd = 1'b0;
        end

        exp_sof = exp_ptr & (cfg_big_ring ? 16'hFFFF : 16'h3FFF);
        exp_ptr = (exp_ptr + bytes) & (cfg_big_ring ? 16'hFFFF : 16'h3FFF);
        if (coincide) begin
            exp_fcnt = 1; exp_bcnt = bytes;
        end else begin
            exp_fcnt = (exp_fcnt + 1) & 12'hFFF; exp_bcnt = (exp_bcnt + bytes) & 16'hFFFF;
        end
        exp_evt = 1;
        chk(buf_release == 1'b1, "R9 release", buf_release, 1);
        check_state("R6/R7/R8 completion");
        chk(dma_req == 3'b000, "R3 idle after last", dma_req, 0);
        @(negedge clk);
        chk(buf_release == 1'b0, "R9 release one cycle", buf_release, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dma_req == 3'b000, "R1 reset req", dma_req, 0);
        check_state("R1 reset");

        // idle acknowledges are ignored
        dma_ack_n = 3'b000;
        repeat (2) @(negedge clk);
        dma_ack_n = 3'b111;
        repeat (2) @(negedge clk);
        chk(dma_req == 3'b000, "R10 idle ack req", dma_req, 0);
        check_state("R10 idle ack");

        // continuous, odd length, channel 0, interrupt enabled
        cfg_irq_en = 1'b1;
        move_frame(16'hC0DE, 9, 0, 0, 0, 0, 0);
        // even length, channel 1, foreign acks on other pairs
        move_frame(16'h1234, 12, 1, 0, 0, 1, 0);
        // zero-length frame on channel 2
        move_frame(16'h00F0, 0, 2, 0, 0, 0, 0);

        // event clear and interrupt gating
        @(negedge clk); evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0; exp_evt = 0;
        check_state("R9 evt clear");

        // plain clear-on-read
        fcnt_rd = 1'b1; bcnt_rd = 1'b1;
        @(negedge clk); fcnt_rd = 1'b0; bcnt_rd = 1'b0;
        exp_fcnt = 0; exp_bcnt = 0;
        check_state("R7/R8 clear");
        chk(frame_count[15:12] == 4'h0, "R7 upper bits", frame_count[15:12], 0);

        // burst pacing with exact phase probe
        cfg_irq_en = 1'b0;
        move_frame(16'hB00B, 120, 1, 1, 1, 0, 0);
        // read coinciding with completion
        move_frame(16'h7777, 31, 0, 0, 0, 0, 1);

        // small ring wrap then large ring
        for (int f = 0; f < 9; f++) begin
            move_frame(16'(16'hA000 + f), 2000 - f, f % 3, 0, 0, 0, 0);
            if (f == 4) begin
                fcnt_rd = 1'b1; bcnt_rd = 1'b1;
                @(negedge clk); fcnt_rd = 1'b0; bcnt_rd = 1'b0;
                exp_fcnt = 0; exp_bcnt = 0;
            end
        end
        cfg_big_ring = 1'b1;
        for (int f = 0; f < 3; f++) move_frame(16'(16'hE000 + f), 1999, 2, f == 1, 0, 0, 0);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule